// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block turns one load request into the memory address that the load must use. A request carries a three-bit addressing mode, a two-bit access-size code, a 32-bit immediate or offset, and up to two register operands: a base and an index. The block returns the final address on a one-cycle response pulse. For the two auto-modify modes, the same pulse also carries the new base value, so that the register file can write it back. An undefined request returns an illegal flag and nothing else.

Memory-indirect mode needs one memory read. The block puts the base value on a read port and holds the request there until memory acknowledges. The returned word then becomes the address. While that read is outstanding, the block refuses new requests. Every other mode answers one clock after the request is accepted, and requests may arrive back to back.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (absolute) returns the immediate as the address and no writeback.
- R2: Mode code 1 (register indirect) returns the base operand as the address and no writeback.
- R3: Mode code 2 (displacement) returns base plus immediate, wrapping modulo 2^32.
- R4: Mode code 3 (indexed) returns base plus index, wrapping modulo 2^32.
- R5: Mode code 4 (memory indirect) raises the read enable with the base as read address and holds both until the acknowledge is sampled. The response follows one cycle after the acknowledge and carries the read data as its address. Ready stays low from acceptance until the response.
- R6: Mode code 5 (post-increment) returns the base as the address and writes back base plus the step, wrapping.
- R7: Mode code 6 (pre-decrement) returns base minus the step as the address and writes that same value back, wrapping.
- R8: The size code selects the step: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. Modes other than 5 and 6 ignore the size code.
- R9: Mode code 7, or mode 5 or 6 with size code 3, responds with the illegal flag set, address zero, no writeback and no memory read.
- R10: A request is accepted on a clock edge where valid and ready are both high. For every mode except 4, the response pulse and any writeback pulse appear in the cycle after acceptance and last one cycle. A writeback pulse never appears without a response pulse.
- R11: After reset, ready is high, and the response, writeback and read-enable outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code |
| req_imm | input | 32 | Immediate or offset |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_addr | output | 32 | Effective address |
| rsp_illegal | output | 1 | Request was undefined |
| wb_valid | output | 1 | Base writeback pulse |
| wb_data | output | 32 | New base value |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rd_data | input | 32 | Memory read data |

## Verification
The bench builds the block with its defaults: a 32-bit address and the memory-indirect variant enabled. With these settings, all eight mode codes can be reached, including the read-port wait with both immediate and delayed acknowledges. Because the width is the full 32 bits, the operands can be placed so that sums, increments and decrements cross the 2^32 boundary. That makes the wrap behaviour of every arithmetic mode visible at the ports.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
   localparam int AM_MODE_W = 3;
   localparam int AM_SIZE_W = 2;

   typedef enum logic [AM_MODE_W-1:0] {
      AM_ABS     = 3'd0,
      AM_REG     = 3'd1,
      AM_DISP    = 3'd2,
      AM_IDX     = 3'd3,
      AM_MIND    = 3'd4,
      AM_POSTINC = 3'd5,
      AM_PREDEC  = 3'd6,
      AM_RSVD    = 3'd7
   } am_mode_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_FETCH = 1'b1
   } ea_state_e;
endpackage

// File: rtl/ea_stepper.sv
module ea_stepper #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size_code,
   output logic              step_ok,
   output logic [ADDR_W-1:0] inc_val,
   output logic [ADDR_W-1:0] dec_val
);
   localparam int           MAX_CODE = 2;
   localparam [ADDR_W-1:0]  ONE      = {{(ADDR_W-1){1'b0}}, 1'b1};

   logic [ADDR_W-1:0] step;

   always_comb begin
      step_ok = (int'(size_code) <= MAX_CODE);
      step    = step_ok ? (ONE << size_code) : '0;
      inc_val = base + step;
      dec_val = base - step;
   end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit HAS_MIND = 1'b1
) (
   input  logic [AM_MODE_W-1:0] mode,
   input  logic [AM_SIZE_W-1:0] size_code,
   input  logic [ADDR_W-1:0]    imm,
   input  logic [ADDR_W-1:0]    base,
   input  logic [ADDR_W-1:0]    index,
   output logic [ADDR_W-1:0]    addr,
   output logic                 illegal,
   output logic                 need_read,
   output logic                 wb_en,
   output logic [ADDR_W-1:0]    wb_val
);
   logic              step_ok;
   logic [ADDR_W-1:0] inc_val;
   logic [ADDR_W-1:0] dec_val;
   logic              mind_ok;

   ea_stepper #(.ADDR_W(ADDR_W), .SIZE_W(AM_SIZE_W)) u_step (
      .base     (base),
      .size_code(size_code),
      .step_ok  (step_ok),
      .inc_val  (inc_val),
      .dec_val  (dec_val)
   );

   generate
      if (HAS_MIND) begin : g_mind_on
         assign mind_ok = 1'b1;
      end else begin : g_mind_off
         assign mind_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      addr      = '0;
      illegal   = 1'b0;
      need_read = 1'b0;
      wb_en     = 1'b0;
      wb_val    = '0;
      case (am_mode_e'(mode))
         AM_ABS:  addr = imm;
         AM_REG:  addr = base;
         AM_DISP: addr = base + imm;
         AM_IDX:  addr = base + index;
         AM_MIND: begin
            if (mind_ok) need_read = 1'b1;
            else         illegal   = 1'b1;
         end
         AM_POSTINC: begin
            if (step_ok) begin
               addr   = base;
               wb_en  = 1'b1;
               wb_val = inc_val;
            end else begin
               illegal = 1'b1;
            end
         end
         AM_PREDEC: begin
            if (step_ok) begin
               addr   = dec_val;
               wb_en  = 1'b1;
               wb_val = dec_val;
            end else begin
               illegal = 1'b1;
            end
         end
         default: illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] calc_addr,
   input  logic              calc_illegal,
   input  logic              calc_need_read,
   input  logic              calc_wb_en,
   input  logic [ADDR_W-1:0] calc_wb_val,
   input  logic [ADDR_W-1:0] base,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_illegal,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rd_data
);
   ea_state_e state;
   logic      accept;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         rsp_valid   <= 1'b0;
         rsp_addr    <= '0;
         rsp_illegal <= 1'b0;
         wb_valid    <= 1'b0;
         wb_data     <= '0;
         mem_rd_en   <= 1'b0;
         mem_rd_addr <= '0;
      end else begin
         rsp_valid <= 1'b0;
         wb_valid  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  if (calc_need_read) begin
                     state       <= ST_FETCH;
                     mem_rd_en   <= 1'b1;
                     mem_rd_addr <= base;
                  end else begin
                     rsp_valid   <= 1'b1;
                     rsp_addr    <= calc_addr;
                     rsp_illegal <= calc_illegal;
                     wb_valid    <= calc_wb_en;
                     wb_data     <= calc_wb_val;
                  end
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  state       <= ST_IDLE;
                  mem_rd_en   <= 1'b0;
                  rsp_valid   <= 1'b1;
                  rsp_addr    <= mem_rd_data;
                  rsp_illegal <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_gen_pkg::*;
#(
   parameter int ADDR_W           = 32,
   parameter bit HAS_MEM_INDIRECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [2:0]        req_mode,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_imm,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [ADDR_W-1:0] req_index,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_illegal,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_data,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_ack,
   input  logic [ADDR_W-1:0] mem_rd_data
);
   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("ea_gen: ADDR_W must be at least 8");
      end
   endgenerate

   logic [ADDR_W-1:0] c_addr;
   logic              c_illegal;
   logic              c_need_read;
   logic              c_wb_en;
   logic [ADDR_W-1:0] c_wb_val;

   ea_calc #(.ADDR_W(ADDR_W), .HAS_MIND(HAS_MEM_INDIRECT)) u_calc (
      .mode     (req_mode),
      .size_code(req_size),
      .imm      (req_imm),
      .base     (req_base),
      .index    (req_index),
      .addr     (c_addr),
      .illegal  (c_illegal),
      .need_read(c_need_read),
      .wb_en    (c_wb_en),
      .wb_val   (c_wb_val)
   );

   ea_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .calc_addr     (c_addr),
      .calc_illegal  (c_illegal),
      .calc_need_read(c_need_read),
      .calc_wb_en    (c_wb_en),
      .calc_wb_val   (c_wb_val),
      .base          (req_base),
      .rsp_valid     (rsp_valid),
      .rsp_addr      (rsp_addr),
      .rsp_illegal   (rsp_illegal),
      .wb_valid      (wb_valid),
      .wb_data       (wb_data),
      .mem_rd_en     (mem_rd_en),
      .mem_rd_addr   (mem_rd_addr),
      .mem_ack       (mem_ack),
      .mem_rd_data   (mem_rd_data)
   );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int ADDR_W   = 32,
   parameter bit HAS_MIND = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        req_mode,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_illegal,
   input logic              wb_valid,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_rd_data
);
   // R10: single-cycle modes answer on the next edge
   assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_mode != 3'd4 || !HAS_MIND)) |=> rsp_valid);

   // R10: writeback only together with a response
   assert_wb_with_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> rsp_valid);

   // R5: read request held steady until acknowledged
   assert_read_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !mem_ack) |=> (mem_rd_en && $stable(mem_rd_addr) && !rsp_valid));

   // R5: acknowledged data becomes the address
   assert_read_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && mem_ack) |=> (rsp_valid && !rsp_illegal && rsp_addr == $past(mem_rd_data)));

   // R5: no acceptance while a read is outstanding
   assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !req_ready);

   // R9: illegal responses carry no address and no writeback
   assert_illegal_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_illegal) |-> (rsp_addr == '0 && !wb_valid && !mem_rd_en));
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W), .HAS_MIND(HAS_MEM_INDIRECT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_mode   (req_mode),
   .rsp_valid  (rsp_valid),
   .rsp_addr   (rsp_addr),
   .rsp_illegal(rsp_illegal),
   .wb_valid   (wb_valid),
   .mem_rd_en  (mem_rd_en),
   .mem_rd_addr(mem_rd_addr),
   .mem_ack    (mem_ack),
   .mem_rd_data(mem_rd_data)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 32;

   typedef struct {
      logic [AW-1:0] addr;
      logic          ill;
      logic          wbv;
      logic [AW-1:0] wbd;
      int            due;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_mode = '0;
   logic [1:0]    req_size = '0;
   logic [AW-1:0] req_imm = '0, req_base = '0, req_index = '0;
   logic          rsp_valid, rsp_illegal, wb_valid, mem_rd_en;
   logic [AW-1:0] rsp_addr, wb_data, mem_rd_addr;
   logic          mem_ack = 1'b0;
   logic [AW-1:0] mem_rd_data;

   exp_t exp_q[$];
   int   n_chk = 0, n_bad = 0, cyc = 0, ack_lat = 0, ack_cnt = 0;
   bit   finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [AW-1:0] mem_word(input logic [AW-1:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
   endfunction

   assign mem_rd_data = mem_word(mem_rd_addr);

   ea_gen uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_mode(req_mode), .req_size(req_size), .req_imm(req_imm),
      .req_base(req_base), .req_index(req_index), .rsp_valid(rsp_valid),
      .rsp_addr(rsp_addr), .rsp_illegal(rsp_illegal), .wb_valid(wb_valid),
      .wb_data(wb_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_ack(mem_ack), .mem_rd_data(mem_rd_data)
   );

   // memory model: acknowledge after ack_lat waiting cycles
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         ack_cnt = 0;
      end else if (mem_rd_en) begin
         if (ack_cnt >= ack_lat) mem_ack = 1'b1;
         else ack_cnt++;
      end
   end

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [2:0] m, input logic [1:0] s,
                                  input logic [AW-1:0] imm, input logic [AW-1:0] b,
                                  input logic [AW-1:0] x);
      exp_t e;
      logic [AW-1:0] st;
      st = (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
      e.addr = '0; e.ill = 1'b0; e.wbv = 1'b0; e.wbd = '0; e.due = -1; e.tag = "";
      case (m)
         3'd0: begin e.addr = imm;    e.tag = "R1"; end
         3'd1: begin e.addr = b;      e.tag = "R2"; end
         3'd2: begin e.addr = b + imm; e.tag = "R3"; end
         3'd3: begin e.addr = b + x;  e.tag = "R4"; end
         3'd4: begin e.addr = mem_word(b); e.tag = "R5"; end
         3'd5: begin
            if (s == 2'd3) begin e.ill = 1'b1; e.tag = "R9"; end
            else begin e.addr = b; e.wbv = 1'b1; e.wbd = b + st; e.tag = "R6"; end
         end
         3'd6: begin
            if (s == 2'd3) begin e.ill = 1'b1; e.tag = "R9"; end
            else begin e.addr = b - st; e.wbv = 1'b1; e.wbd = b - st; e.tag = "R7"; end
         end
         default: begin e.ill = 1'b1; e.tag = "R9"; end
      endcase
      return e;
   endfunction

   // driver: called at a negative edge, returns at a negative edge
   task automatic send(input logic [2:0] m, input logic [1:0] s, input logic [AW-1:0] imm,
                       input logic [AW-1:0] b, input logic [AW-1:0] x);
      exp_t e;
      while (!req_ready) @(negedge clk);
      req_mode = m; req_size = s; req_imm = imm; req_base = b; req_index = x;
      req_valid = 1'b1;
      e = model(m, s, imm, b, x);
      if (m != 3'd4) e.due = cyc + 1;   // R10 timing
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: actual unexpected response expected none");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, rsp_addr, e.addr);
            check(e.tag, {31'd0, rsp_illegal}, {31'd0, e.ill});
            check(e.tag, {31'd0, wb_valid}, {31'd0, e.wbv});
            if (e.wbv) check(e.tag, wb_data, e.wbd);
            if (e.ill) check("R9", {31'd0, mem_rd_en}, 32'd0);
            if (e.due >= 0) check("R10", cyc, e.due);
         end
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", {31'd0, req_ready}, 32'd1);
      check("R11", {31'd0, rsp_valid}, 32'd0);
      check("R11", {31'd0, wb_valid}, 32'd0);
      check("R11", {31'd0, mem_rd_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1..R4, with R8 size code ignored, back to back for R10
      send(3'd0, 2'd3, 32'hDEAD_BEEF, 32'h1, 32'h2);
      send(3'd1, 2'd2, 32'h0, 32'h0000_1234, 32'h0);
      send(3'd2, 2'd0, 32'h0000_0020, 32'hFFFF_FFF0, 32'h0);
      send(3'd3, 2'd1, 32'h0, 32'h8000_0000, 32'h8000_0004);
      send(3'd2, 2'd3, 32'hFFFF_FFFF, 32'h0000_0010, 32'h0);
      drain();

      // R6, R7, R8: step sizes and wrap
      send(3'd5, 2'd0, 32'h0, 32'h0000_1000, 32'h0);
      send(3'd5, 2'd1, 32'h0, 32'h0000_1000, 32'h0);
      send(3'd5, 2'd2, 32'h0, 32'hFFFF_FFFE, 32'h0);
      send(3'd6, 2'd0, 32'h0, 32'h0000_0000, 32'h0);
      send(3'd6, 2'd1, 32'h0, 32'h0000_0100, 32'h0);
      send(3'd6, 2'd2, 32'h0, 32'h0000_0002, 32'h0);
      drain();

      // R9: undefined requests
      send(3'd7, 2'd0, 32'h1234_5678, 32'h9, 32'h9);
      send(3'd5, 2'd3, 32'h0, 32'h40, 32'h0);
      send(3'd6, 2'd3, 32'h0, 32'h40, 32'h0);
      drain();

      // R5: memory indirect, immediate acknowledge
      ack_lat = 0;
      send(3'd4, 2'd0, 32'h0, 32'hCAFE_0010, 32'h0);
      drain();

      // R5: delayed acknowledge, busy and read address visible
      ack_lat = 3;
      send(3'd4, 2'd1, 32'h0, 32'h0BAD_F00D, 32'h0);
      check("R5", {31'd0, mem_rd_en}, 32'd1);
      check("R5", mem_rd_addr, 32'h0BAD_F00D);
      check("R5", {31'd0, req_ready}, 32'd0);
      send(3'd1, 2'd0, 32'h0, 32'h7777_0000, 32'h0);
      drain();

      // R10: mixed stream
      ack_lat = 1;
      send(3'd3, 2'd0, 32'h0, 32'h10, 32'h20);
      send(3'd4, 2'd0, 32'h0, 32'h0000_ABCD, 32'h0);
      send(3'd5, 2'd2, 32'h0, 32'h100, 32'h0);
      send(3'd7, 2'd2, 32'h0, 32'h100, 32'h0);
      drain();

      check("R10", exp_q.size(), 0);
      finished = 1'b1;
   end

   initial begin
      fork
         begin
            wait (finished);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule